// File: doc/BRIEF.md
# Descriptor Table Walker

This block turns a 32-bit virtual address into a physical address by following a chain of descriptors kept in memory. A walk starts from a root pointer that has the same layout as a long table descriptor: an attribute word and an address word. At each step the 2-bit type code in the low bits of the current attribute word chooses what happens next. The walk can fault, end on a page, descend into a table of 32-bit short descriptors, or descend into a table of 64-bit long descriptors. The page can therefore be found at any depth, and a shallower hit maps a larger region.

Memory is reached through a single word port with a request/valid handshake. The walker also maintains the reference and dirty bookkeeping in the descriptors themselves. When a fetched descriptor has its used bit clear, the walker writes the attribute word back with that bit set. On a permitted write, it also sets the modified bit of the final page descriptor. Only one walk runs at a time. The result appears for a single cycle with a done pulse.

Top module: `ptw_walker`

## Requirements
- R1: After reset, busy, done and memReq are low.
- R2: The type code is attribute bits 1..0: 00 invalid, 01 page, 10 short (4-byte) table, 11 long (8-byte) table. The root pointer is decoded like any descriptor. A root of type 01 maps the virtual address straight through (physAddr equals reqVaddr).
- R3: A table descriptor's next base is bits 31..4 of its address word, with the low four bits taken as zero. The entry address is base + index×8 for a long table and base + index×4 for a short table. A long entry is read as the attribute word at the entry address, then the address word at +4. A short entry is one word that serves as both.
- R4: The index into the first-level table is virtual bits 31..25, into the second level bits 24..18, and into the third level bits 17..13.
- R5: A type 01 descriptor ends the walk. physAddr takes bits 31..8 of the page base (low eight zero) above the kept span, and the virtual address bits within the kept span. The kept span is bits 24..0 at level 1, 17..0 at level 2 and 12..0 at level 3. endLevel gives the level: 0 root, 1, 2 or 3.
- R6: A type 00 descriptor at any level, or a table type at level 3, gives transFault with endLevel set to that level. In that case physAddr and wpOut are 0, and the descriptor is not written.
- R7: wpOut is the OR of the write-protect bits (attribute bit 2) of every descriptor on the walk, including the root.
- R8: A write access whose walk has any write-protect bit set gives protFault, with physAddr 0, and does not set the modified bit.
- R9: A fetched descriptor whose used bit (attribute bit 3) is clear is written back at its attribute-word address with that bit set. A descriptor whose used bit is already set causes no memory write.
- R10: A write access with no write-protect on its walk sets the modified bit (attribute bit 4) of the final page descriptor by a write-back.
- R11: busy is high from the cycle after a request is accepted until the result. done is a one-cycle pulse with the results valid in that cycle. A request raised while busy is ignored.
- R12: memReq, memAddr and memWe hold steady until memValid. memReq is only raised during a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootAttr | input | 32 | Root pointer attribute word |
| rootAddr | input | 32 | Root pointer address word |
| reqValid | input | 1 | Start a walk (taken when idle) |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| busy | output | 1 | Walk in progress |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address (word aligned) |
| memWdata | output | 32 | Memory write data |
| memValid | input | 1 | Memory response / acknowledge |
| memRdata | input | 32 | Memory read data |
| done | output | 1 | Result valid pulse |
| physAddr | output | 32 | Translated physical address |
| wpOut | output | 1 | Accumulated write protect |
| transFault | output | 1 | Translation fault |
| protFault | output | 1 | Protection fault |
| endLevel | output | 2 | Level where the walk ended |

## Verification
Some rules are checked on every cycle. These are the memory handshake holding still until acknowledged, requests only inside a walk, the single-cycle done pulse with busy already low, exclusive fault kinds, a protection fault always showing write protect, and every write-back carrying a set used bit. The scenarios alone can show the rest: the physical address at each termination depth, the long versus short entry addressing, the fault level codes, and the exact descriptor words left in memory after used and modified updates. The same holds for the absence of a write when nothing needed changing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    DT_NONE  = 2'b00,
    DT_PAGE  = 2'b01,
    DT_SHORT = 2'b10,
    DT_LONG  = 2'b11
  } descType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRoot;
    logic capAttr;
    logic capAddr;
    logic capWb;
    logic descend;
    logic finish;
    logic tFault;
    logic pFault;
    logic memRd;
    logic memWr;
    logic hiWord;
  } walkCtl_t;

  // decoded status from datapath to control
  typedef struct packed {
    descType_e dtype;
    logic      needWb;
    logic      lastLevel;
    logic      isLong;
    logic      protHit;
  } walkSts_t;

  localparam int WP_BIT   = 2;
  localparam int USED_BIT = 3;
  localparam int MOD_BIT  = 4;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memValid,
  input  walkSts_t sts,
  output walkCtl_t ctl,
  output logic     busy
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_FETCH_LO, ST_FETCH_HI, ST_WRITEBACK
  } state_e;

  state_e state, stateNext;
  logic   isTable;

  assign isTable = sts.dtype[1];
  assign busy    = (state != ST_IDLE);

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadRoot = 1'b1;
          stateNext    = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (sts.dtype == DT_NONE || (isTable && sts.lastLevel)) begin
          ctl.finish = 1'b1;
          ctl.tFault = 1'b1;
          stateNext  = ST_IDLE;
        end else if (sts.needWb) begin
          stateNext = ST_WRITEBACK;
        end else if (sts.dtype == DT_PAGE) begin
          ctl.finish = 1'b1;
          ctl.pFault = sts.protHit;
          stateNext  = ST_IDLE;
        end else begin
          ctl.descend = 1'b1;
          stateNext   = ST_FETCH_LO;
        end
      end
      ST_FETCH_LO: begin
        ctl.memRd = 1'b1;
        if (memValid) begin
          ctl.capAttr = 1'b1;
          stateNext   = sts.isLong ? ST_FETCH_HI : ST_DECIDE;
        end
      end
      ST_FETCH_HI: begin
        ctl.memRd  = 1'b1;
        ctl.hiWord = 1'b1;
        if (memValid) begin
          ctl.capAddr = 1'b1;
          stateNext   = ST_DECIDE;
        end
      end
      ST_WRITEBACK: begin
        ctl.memWr = 1'b1;
        if (memValid) begin
          ctl.capWb = 1'b1;
          stateNext = ST_DECIDE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/ptw_dp.sv
module ptw_dp
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int A_BITS = 7,
  parameter int B_BITS = 7,
  parameter int C_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  output walkSts_t          sts,
  input  logic [ADDR_W-1:0] rootAttr,
  input  logic [ADDR_W-1:0] rootAddr,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic              done,
  output logic [ADDR_W-1:0] physAddr,
  output logic              wpOut,
  output logic              transFault,
  output logic              protFault,
  output logic [1:0]        endLevel
);

  localparam int SH_A = ADDR_W - A_BITS;
  localparam int SH_B = SH_A - B_BITS;
  localparam int SH_C = SH_B - C_BITS;
  localparam logic [ADDR_W-1:0] ONE    = 1;
  localparam logic [ADDR_W-1:0] MASK_A = (ONE << SH_A) - ONE;
  localparam logic [ADDR_W-1:0] MASK_B = (ONE << SH_B) - ONE;
  localparam logic [ADDR_W-1:0] MASK_C = (ONE << SH_C) - ONE;

  logic [ADDR_W-1:0] vaReg, attrW, addrW, descAddr;
  logic              wrReg, wpAcc, isLong;
  logic [1:0]        level;

  logic              wpTotal, isPage;
  logic [ADDR_W-1:0] wbWord, idx, nextAddr, keepMask, pageBase, physNext;

  assign isPage  = (descType_e'(attrW[1:0]) == DT_PAGE);
  assign wpTotal = wpAcc | attrW[WP_BIT];

  always_comb begin
    wbWord = attrW;
    wbWord[USED_BIT] = 1'b1;
    if (isPage && wrReg && !wpTotal) wbWord[MOD_BIT] = 1'b1;
  end

  // index for the level being entered
  always_comb begin
    unique case (level)
      2'd0:    idx = ADDR_W'(vaReg[SH_A +: A_BITS]);
      2'd1:    idx = ADDR_W'(vaReg[SH_B +: B_BITS]);
      2'd2:    idx = ADDR_W'(vaReg[SH_C +: C_BITS]);
      default: idx = '0;
    endcase
  end

  assign nextAddr = {addrW[ADDR_W-1:4], 4'b0000} + (attrW[0] ? (idx << 3) : (idx << 2));

  always_comb begin
    unique case (level)
      2'd0:    keepMask = '1;
      2'd1:    keepMask = MASK_A;
      2'd2:    keepMask = MASK_B;
      default: keepMask = MASK_C;
    endcase
  end

  assign pageBase = {addrW[ADDR_W-1:8], 8'h00};
  assign physNext = (pageBase & ~keepMask) | (vaReg & keepMask);

  assign sts.dtype     = descType_e'(attrW[1:0]);
  assign sts.needWb    = (level != 2'd0) && (wbWord != attrW);
  assign sts.lastLevel = (level == 2'd3);
  assign sts.isLong    = isLong;
  assign sts.protHit   = wrReg && wpTotal;

  assign memAddr  = descAddr + (ctl.hiWord ? ADDR_W'(4) : '0);
  assign memWdata = wbWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg <= '0; attrW <= '0; addrW <= '0; descAddr <= '0;
      wrReg <= 1'b0; wpAcc <= 1'b0; isLong <= 1'b0; level <= '0;
    end else begin
      if (ctl.loadRoot) begin
        vaReg  <= reqVaddr;
        wrReg  <= reqWrite;
        attrW  <= rootAttr;
        addrW  <= rootAddr;
        level  <= '0;
        wpAcc  <= 1'b0;
        isLong <= 1'b1;
      end
      if (ctl.capAttr) begin
        attrW <= memRdata;
        if (!isLong) addrW <= memRdata;
      end
      if (ctl.capAddr) addrW <= memRdata;
      if (ctl.capWb) begin
        attrW <= wbWord;
        if (!isLong) addrW <= wbWord;
      end
      if (ctl.descend) begin
        descAddr <= nextAddr;
        level    <= level + 2'd1;
        isLong   <= attrW[0];
        wpAcc    <= wpTotal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0; physAddr <= '0; wpOut <= 1'b0;
      transFault <= 1'b0; protFault <= 1'b0; endLevel <= '0;
    end else begin
      done <= ctl.finish;
      if (ctl.finish) begin
        transFault <= ctl.tFault;
        protFault  <= ctl.pFault;
        endLevel   <= level;
        wpOut      <= ctl.tFault ? 1'b0 : wpTotal;
        physAddr   <= (ctl.tFault || ctl.pFault) ? '0 : physNext;
      end
    end
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int A_BITS = 7,
  parameter int B_BITS = 7,
  parameter int C_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rootAttr,
  input  logic [ADDR_W-1:0] rootAddr,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memValid,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              done,
  output logic [ADDR_W-1:0] physAddr,
  output logic              wpOut,
  output logic              transFault,
  output logic              protFault,
  output logic [1:0]        endLevel
);

  walkCtl_t ctl;
  walkSts_t sts;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memValid(memValid),
    .sts(sts), .ctl(ctl), .busy(busy)
  );

  ptw_dp #(.ADDR_W(ADDR_W), .A_BITS(A_BITS), .B_BITS(B_BITS), .C_BITS(C_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sts(sts),
    .rootAttr(rootAttr), .rootAddr(rootAddr), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .done(done), .physAddr(physAddr), .wpOut(wpOut),
    .transFault(transFault), .protFault(protFault), .endLevel(endLevel)
  );

  assign memReq = ctl.memRd | ctl.memWr;
  assign memWe  = ctl.memWr;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] memWdata,
  input logic              memValid,
  input logic              done,
  input logic [ADDR_W-1:0] physAddr,
  input logic              wpOut,
  input logic              transFault,
  input logic              protFault
);

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr) && $stable(memWe));

  p_mem_in_walk_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  p_fault_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(transFault && protFault));

  p_tfault_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    done && transFault |-> physAddr == '0 && !wpOut);

  p_prot_wp_r8: assert property (@(posedge clk) disable iff (!rstN)
    done && protFault |-> wpOut && physAddr == '0);

  p_wb_used_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[3]);

endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
  .memValid(memValid), .done(done), .physAddr(physAddr), .wpOut(wpOut),
  .transFault(transFault), .protFault(protFault)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] rootAttr = 32'h3, rootAddr = 32'h100;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        busy, memReq, memWe, memValid;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        done, wpOut, transFault, protFault;
  logic [31:0] physAddr;
  logic [1:0]  endLevel;

  always #10 clk = ~clk;  // 50 MHz

  ptw_walker u0 (
    .clk(clk), .rstN(rstN), .rootAttr(rootAttr), .rootAddr(rootAddr),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqWrite(reqWrite), .busy(busy),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memValid(memValid), .memRdata(memRdata), .done(done), .physAddr(physAddr),
    .wpOut(wpOut), .transFault(transFault), .protFault(protFault), .endLevel(endLevel)
  );

  // word memory, 4 KB, responds one cycle after a request
  logic [31:0] mem [0:1023];
  int          wrCount = 0;
  int          hsErr = 0;
  logic        prevPending = 1'b0;
  logic [31:0] prevAddr = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memRdata <= '0;
    end else begin
      memValid <= memReq && !memValid;
      if (memReq && !memValid) begin
        if (memWe) begin
          mem[memAddr[11:2]] <= memWdata;
          wrCount <= wrCount + 1;
        end
        memRdata <= mem[memAddr[11:2]];
      end
    end
  end

  // handshake monitor (R12)
  always @(negedge clk) begin
    if (rstN) begin
      if (prevPending && (!memReq || memAddr != prevAddr)) hsErr <= hsErr + 1;
      prevPending <= memReq && !memValid;
      prevAddr    <= memAddr;
    end
  end

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] rPhys;
  logic        rWp, rTf, rPf;
  logic [1:0]  rLvl;
  logic        sawBusy;

  task automatic walk(input logic [31:0] va, input logic wr, input logic noise);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr;
    @(negedge clk);
    sawBusy = busy;
    if (noise) begin
      reqVaddr = 32'h06000000; reqWrite = 1'b1;
    end else reqValid = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL R11 walk timeout actual=%0d expected=done", n);
    end
    rPhys = physAddr; rWp = wpOut; rTf = transFault; rPf = protFault; rLvl = endLevel;
  endtask

  function automatic void poke(input logic [31:0] a, input logic [31:0] v);
    mem[a[11:2]] = v;
  endfunction

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [31:0] phys;
    logic        wp;
    logic        tf;
    logic        pf;
    logic [1:0]  lvl;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h02086ABC, 1'b0, 32'h12344ABC, 1'b0, 1'b0, 1'b0, 2'd3},  // R3 R4 R5 R9
    '{32'h02086ABC, 1'b1, 32'h12344ABC, 1'b0, 1'b0, 1'b0, 2'd3},  // R10
    '{32'h04155AA5, 1'b0, 32'h7E155AA5, 1'b1, 1'b0, 1'b0, 2'd1},  // R5 R7 long page
    '{32'h04155AA5, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b1, 2'd1},  // R8
    '{32'h06000000, 1'b0, 32'h00000000, 1'b0, 1'b1, 1'b0, 2'd1},  // R6
    '{32'h08140000, 1'b0, 32'h00000000, 1'b0, 1'b1, 1'b0, 2'd2},  // R6
    '{32'h081AA5A5, 1'b1, 32'h5552A5A5, 1'b0, 1'b0, 1'b0, 2'd2},  // R5 R10
    '{32'h081C2000, 1'b0, 32'h00000000, 1'b0, 1'b1, 1'b0, 2'd3},  // R6 table at last level
    '{32'h081C5F0F, 1'b0, 32'h9ABCDF0F, 1'b1, 1'b0, 1'b0, 2'd3},  // R7
    '{32'h081C5F0F, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b1, 2'd3}   // R8
  };

  initial begin
    int w0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    poke(32'h108, 32'h00000002); poke(32'h10C, 32'h00000600);
    poke(32'h110, 32'h0000000D); poke(32'h114, 32'h7F000000);
    poke(32'h118, 32'h00000000);
    poke(32'h120, 32'h0000000A); poke(32'h124, 32'h00000A00);
    poke(32'h608, 32'h0000080A);
    poke(32'h80C, 32'h12345601);
    poke(32'hA14, 32'h00000000);
    poke(32'hA18, 32'h55500009);
    poke(32'hA1C, 32'h00000C0E);
    poke(32'hC04, 32'h00000003);
    poke(32'hC08, 32'h9ABCDE09);

    repeat (3) @(negedge clk);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 memReq", {31'b0, memReq}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      walk(VECS[i].va, VECS[i].wr, 1'b0);
      chk($sformatf("R5 vec%0d phys", i), rPhys, VECS[i].phys);
      chk($sformatf("R7 vec%0d wp", i), {31'b0, rWp}, {31'b0, VECS[i].wp});
      chk($sformatf("R6 vec%0d transFault", i), {31'b0, rTf}, {31'b0, VECS[i].tf});
      chk($sformatf("R8 vec%0d protFault", i), {31'b0, rPf}, {31'b0, VECS[i].pf});
      chk($sformatf("R2 vec%0d endLevel", i), {30'b0, rLvl}, {30'b0, VECS[i].lvl});
    end

    // descriptor contents left in memory
    chk("R9 used set on level-1 long", mem[32'h108 >> 2], 32'h0000000A);
    chk("R10 modified set on level-3 page", mem[32'h80C >> 2], 32'h12345619);
    chk("R10 modified set on level-2 page", mem[32'hA18 >> 2], 32'h55500019);
    chk("R8 modified not set when protected", mem[32'hC08 >> 2], 32'h9ABCDE09);
    chk("R8 long page untouched", mem[32'h110 >> 2], 32'h0000000D);
    chk("R6 no write-back on faulting entry", mem[32'hC04 >> 2], 32'h00000003);

    // R9: no write when all used bits already set
    w0 = wrCount;
    walk(32'h02086ABC, 1'b0, 1'b0);
    chk("R9 no write-back when used set", wrCount - w0, 0);

    // R11: busy during walk, one-cycle done, request ignored while busy
    walk(32'h04155AA5, 1'b0, 1'b1);
    chk("R11 busy during walk", {31'b0, sawBusy}, 32'd1);
    chk("R11 first request result kept", rPhys, 32'h7E155AA5);
    @(negedge clk);
    chk("R11 done lasts one cycle", {31'b0, done}, 32'd0);
    repeat (20) @(negedge clk);
    chk("R11 ignored request started nothing", {30'b0, busy, done}, 32'd0);

    // R2: root decode cases
    rootAttr = 32'h0;
    walk(32'h02086ABC, 1'b0, 1'b0);
    chk("R2 invalid root faults", {31'b0, rTf}, 32'd1);
    chk("R6 root fault level", {30'b0, rLvl}, 32'd0);
    rootAttr = 32'h1;
    walk(32'hDEADBEEF, 1'b0, 1'b0);
    chk("R2 page root passes through", rPhys, 32'hDEADBEEF);
    rootAttr = 32'h7;
    walk(32'h02086ABC, 1'b0, 1'b0);
    chk("R7 root write-protect seen", {31'b0, rWp}, 32'd1);
    chk("R3 walk through long root", rPhys, 32'h12344ABC);
    walk(32'h02086ABC, 1'b1, 1'b0);
    chk("R8 root protect gives protFault", {31'b0, rPf}, 32'd1);

    chk("R12 handshake held until valid", hsErr, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL R11 watchdog actual=expired expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    end
    $finish;
  end

endmodule